// File: doc/BRIEF.md
# Shifted-Operand Data-Processing ALU

This block is the combinational core of a 32-bit integer data path. It builds a second operand from one of three sources, runs one of seventeen data-processing operations on it and the first operand, and produces a result, a result write-enable and an updated set of four condition flags: negative, zero, carry and overflow. The second operand can be a small immediate, a register shifted by a constant amount, or a register rotated right by one position through the carry flag. The operand shifter produces both the operand and a carry-out. Logical operations report that carry-out as their carry flag.

The surrounding pipeline drives the opcode, both operands, the operand-source controls, the current flags and a set-flags control. It takes the result and write-enable for the register file and the new flags for the status register. There is no clock. Every output follows the inputs combinationally.

Top module: `shift_dp_alu`

## Requirements
- R1: With `op2_src` = 0 the second operand is `imm8` zero-extended to 32 bits, and the shifter carry-out equals the incoming carry (`flags_in[1]`).
- R2: With `op2_src` = 1 and `shift_amt` from 1 to 31, `rm` is shifted by `shift_kind` (0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right). The carry-out is the last bit shifted out. For rotate right it is bit 31 of the rotated value.
- R3: With `op2_src` = 1 and `shift_amt` = 0, `rm` passes through unchanged and the carry-out equals the incoming carry, for every `shift_kind`.
- R4: With `op2_src` = 2 or 3, the operand is `rm` rotated right by one with the incoming carry entering bit 31, and the carry-out is `rm[0]`.
- R5: The arithmetic opcodes compute these results: 7 rn+op2, 8 rn+op2+C, 9 rn-op2, 10 rn-op2-(1-C), 11 op2-rn, 12 op2-rn-(1-C).
- R6: For the arithmetic opcodes and opcodes 13/14, the carry flag is the adder carry-out, which is not-borrow for subtraction. The overflow flag is signed overflow.
- R7: The logical opcodes compute these results: 0 op2, 1 ~op2, 2 rn&op2, 3 rn|op2, 4 rn^op2, 5 rn|~op2, 6 rn&~op2.
- R8: For the logical opcodes and opcodes 15/16, the carry flag takes the shifter carry-out and the overflow flag keeps `flags_in[0]`.
- R9: Opcodes 13, 14, 15 and 16 compute rn-op2, rn+op2, rn&op2 and rn^op2 respectively. `result` shows that value, `write_en` stays low, and the flags update as for the matching operation.
- R10: When flags update, N (`flags_out[3]`) is bit 31 of the computed value and Z (`flags_out[2]`) is set exactly when all 32 bits are zero. This includes the compare opcodes.
- R11: With `set_flags` low, `flags_out` equals `flags_in` for every opcode.
- R12: Opcodes 17 to 31 are reserved. They give `result` = 0 and `write_en` low, and leave `flags_out` equal to `flags_in`.
- R13: `write_en` is high for opcodes 0 to 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 5 | Operation select (encoding in R5, R7, R9, R12) |
| rn | input | 32 | First operand |
| rm | input | 32 | Register source for the second operand |
| imm8 | input | 8 | Immediate source for the second operand |
| op2_src | input | 2 | 0 immediate, 1 shifted register, 2/3 rotate through carry |
| shift_kind | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| shift_amt | input | 5 | Constant shift amount 0..31 |
| set_flags | input | 1 | Allow the flags to update |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Computed value |
| write_en | output | 1 | Result should be written |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
The hardest cases to reach are the ones where the flags depend on values at the edge of a range. These include a carry-out taken from bit 0 or bit 31 of `rm` at shift amounts 1 and 31, signed overflow on the carry-consuming subtractions, and a zero result from a compare. Uniform random operands almost never produce them. The stimulus therefore starts with directed vectors that set up each such value on purpose: operands near 0x7FFFFFFF and 0x80000000, equal operands for compares, and carry-in of both polarities. It then runs thousands of pseudo-random vectors in which the shift amount is forced to 0, 1 or 31 a good share of the time. Every vector is compared against a behavioural model in wide integers.

// File: rtl/shift_alu_pkg.sv
package shift_alu_pkg;

    typedef enum logic [4:0] {
        OP_MOV = 5'd0,  OP_MVN = 5'd1,  OP_AND = 5'd2,  OP_ORR = 5'd3,
        OP_EOR = 5'd4,  OP_ORN = 5'd5,  OP_BIC = 5'd6,  OP_ADD = 5'd7,
        OP_ADC = 5'd8,  OP_SUB = 5'd9,  OP_SBC = 5'd10, OP_RSB = 5'd11,
        OP_RSC = 5'd12, OP_CMP = 5'd13, OP_CMN = 5'd14, OP_TST = 5'd15,
        OP_TEQ = 5'd16
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_IMM   = 2'd0,
        SRC_SHIFT = 2'd1,
        SRC_RRX   = 2'd2
    } op2_src_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_e;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_ARITH = 2'd1,
        CLS_LOGIC = 2'd2
    } op_class_e;

    typedef enum logic [2:0] {
        AR_ADD, AR_ADC, AR_SUB, AR_SBC, AR_RSB, AR_RSC
    } arith_e;

    typedef enum logic [2:0] {
        LG_MOV, LG_MVN, LG_AND, LG_ORR, LG_EOR, LG_ORN, LG_BIC
    } logic_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        op_class_e cls;
        arith_e    ak;
        logic_e    lk;
        logic      writes;
    } op_ctrl_t;

    function automatic op_ctrl_t decode_op(logic [4:0] code);
        op_ctrl_t c;
        c = '{cls: CLS_NONE, ak: AR_ADD, lk: LG_MOV, writes: 1'b0};
        case (code)
            OP_MOV: c = '{CLS_LOGIC, AR_ADD, LG_MOV, 1'b1};
            OP_MVN: c = '{CLS_LOGIC, AR_ADD, LG_MVN, 1'b1};
            OP_AND: c = '{CLS_LOGIC, AR_ADD, LG_AND, 1'b1};
            OP_ORR: c = '{CLS_LOGIC, AR_ADD, LG_ORR, 1'b1};
            OP_EOR: c = '{CLS_LOGIC, AR_ADD, LG_EOR, 1'b1};
            OP_ORN: c = '{CLS_LOGIC, AR_ADD, LG_ORN, 1'b1};
            OP_BIC: c = '{CLS_LOGIC, AR_ADD, LG_BIC, 1'b1};
            OP_ADD: c = '{CLS_ARITH, AR_ADD, LG_MOV, 1'b1};
            OP_ADC: c = '{CLS_ARITH, AR_ADC, LG_MOV, 1'b1};
            OP_SUB: c = '{CLS_ARITH, AR_SUB, LG_MOV, 1'b1};
            OP_SBC: c = '{CLS_ARITH, AR_SBC, LG_MOV, 1'b1};
            OP_RSB: c = '{CLS_ARITH, AR_RSB, LG_MOV, 1'b1};
            OP_RSC: c = '{CLS_ARITH, AR_RSC, LG_MOV, 1'b1};
            OP_CMP: c = '{CLS_ARITH, AR_SUB, LG_MOV, 1'b0};
            OP_CMN: c = '{CLS_ARITH, AR_ADD, LG_MOV, 1'b0};
            OP_TST: c = '{CLS_LOGIC, AR_ADD, LG_AND, 1'b0};
            OP_TEQ: c = '{CLS_LOGIC, AR_ADD, LG_EOR, 1'b0};
            default: c = '{CLS_NONE, AR_ADD, LG_MOV, 1'b0};
        endcase
        return c;
    endfunction

    function automatic logic is_compare(logic [4:0] code);
        return (code == OP_CMP) || (code == OP_CMN) ||
               (code == OP_TST) || (code == OP_TEQ);
    endfunction

endpackage

// File: rtl/alu_opnd_shifter.sv
module alu_opnd_shifter
    import shift_alu_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 8,
    parameter int SA_W  = $clog2(W)
) (
    input  logic [W-1:0]     rm,
    input  logic [IMM_W-1:0] imm,
    input  logic [1:0]       src,
    input  logic [1:0]       kind,
    input  logic [SA_W-1:0]  amt,
    input  logic             cin,
    output logic [W-1:0]     opnd,
    output logic             cout
);

    logic [W-1:0] imm_ext;
    logic [W:0]   lsl_ext;
    logic [W:0]   lsr_ext;
    logic [W:0]   asr_ext;
    logic [W-1:0] ror_v;

    generate
        if (IMM_W < W) begin : g_imm_pad
            assign imm_ext = {{(W - IMM_W){1'b0}}, imm};
        end else begin : g_imm_full
            assign imm_ext = imm[W-1:0];
        end
    endgenerate

    always_comb begin
        lsl_ext = {1'b0, rm} << amt;
        lsr_ext = {rm, 1'b0} >> amt;
        asr_ext = $signed({rm, 1'b0}) >>> amt;
        ror_v   = (rm >> amt) | (rm << (W - int'(amt)));

        opnd = rm;
        cout = cin;
        if (src == SRC_IMM) begin
            opnd = imm_ext;
            cout = cin;
        end else if (src[1]) begin
            opnd = {cin, rm[W-1:1]};
            cout = rm[0];
        end else if (amt != '0) begin
            case (shift_e'(kind))
                SH_LSL: begin opnd = lsl_ext[W-1:0]; cout = lsl_ext[W]; end
                SH_LSR: begin opnd = lsr_ext[W:1];   cout = lsr_ext[0]; end
                SH_ASR: begin opnd = asr_ext[W:1];   cout = asr_ext[0]; end
                default: begin opnd = ror_v;         cout = ror_v[W-1]; end
            endcase
        end
    end

    always_comb begin
        if (src == SRC_IMM) begin
            assert_imm_upper_zero_R1: assert (opnd[W-1:IMM_W] == '0 && cout == cin)
                else $error("immediate operand not zero-extended");
        end
        if (src == SRC_SHIFT && amt == '0) begin
            assert_zero_amount_pass_R3: assert (opnd == rm && cout == cin)
                else $error("zero shift altered operand or carry");
        end
        if (src == SRC_SHIFT && amt != '0 && kind == SH_LSL) begin
            assert_lsl_low_zero_R2: assert (opnd[0] == 1'b0)
                else $error("left shift left a set low bit");
        end
        if (src[1]) begin
            assert_rrx_carry_top_R4: assert (opnd[W-1] == cin && cout == rm[0])
                else $error("rotate through carry wrong");
        end
    end

endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
    import shift_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  arith_e       kind,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] value,
    output logic         cout,
    output logic         ovf
);

    logic [W-1:0] x;
    logic [W-1:0] y;
    logic         ci;
    logic [W:0]   sum;

    always_comb begin
        x  = a;
        y  = b;
        ci = 1'b0;
        case (kind)
            AR_ADD: begin x = a; y = b;  ci = 1'b0; end
            AR_ADC: begin x = a; y = b;  ci = cin;  end
            AR_SUB: begin x = a; y = ~b; ci = 1'b1; end
            AR_SBC: begin x = a; y = ~b; ci = cin;  end
            AR_RSB: begin x = b; y = ~a; ci = 1'b1; end
            AR_RSC: begin x = b; y = ~a; ci = cin;  end
            default: begin x = a; y = b; ci = 1'b0; end
        endcase
        sum   = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
        value = sum[W-1:0];
        cout  = sum[W];
        ovf   = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end

    always_comb begin
        if (kind == AR_ADD && a[W-1] != b[W-1]) begin
            assert_mixed_sign_no_ovf_R6: assert (!ovf)
                else $error("overflow flagged on mixed-sign add");
        end
        if (kind == AR_SUB && a == b) begin
            assert_equal_sub_zero_R6: assert (value == '0 && cout)
                else $error("equal subtract not zero with carry");
        end
    end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import shift_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic_e       kind,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] value
);

    always_comb begin
        case (kind)
            LG_MOV:  value = b;
            LG_MVN:  value = ~b;
            LG_AND:  value = a & b;
            LG_ORR:  value = a | b;
            LG_EOR:  value = a ^ b;
            LG_ORN:  value = a | ~b;
            LG_BIC:  value = a & ~b;
            default: value = b;
        endcase
    end

endmodule

// File: rtl/shift_dp_alu.sv
module shift_dp_alu
    import shift_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int SA_W   = $clog2(DATA_W)
) (
    input  logic [4:0]        opcode,
    input  logic [DATA_W-1:0] rn,
    input  logic [DATA_W-1:0] rm,
    input  logic [IMM_W-1:0]  imm8,
    input  logic [1:0]        op2_src,
    input  logic [1:0]        shift_kind,
    input  logic [SA_W-1:0]   shift_amt,
    input  logic              set_flags,
    input  logic [3:0]        flags_in,
    output logic [DATA_W-1:0] result,
    output logic              write_en,
    output logic [3:0]        flags_out
);

    op_ctrl_t          ctrl;
    flags_t            cur;
    flags_t            nxt;
    logic [DATA_W-1:0] op2;
    logic              sh_c;
    logic [DATA_W-1:0] ar_val;
    logic              ar_c;
    logic              ar_v;
    logic [DATA_W-1:0] lg_val;
    logic [DATA_W-1:0] value;

    assign ctrl = decode_op(opcode);
    assign cur  = flags_t'(flags_in);

    alu_opnd_shifter #(.W(DATA_W), .IMM_W(IMM_W), .SA_W(SA_W)) u_shift (
        .rm   (rm),
        .imm  (imm8),
        .src  (op2_src),
        .kind (shift_kind),
        .amt  (shift_amt),
        .cin  (cur.c),
        .opnd (op2),
        .cout (sh_c)
    );

    alu_arith_unit #(.W(DATA_W)) u_arith (
        .kind  (ctrl.ak),
        .a     (rn),
        .b     (op2),
        .cin   (cur.c),
        .value (ar_val),
        .cout  (ar_c),
        .ovf   (ar_v)
    );

    alu_logic_unit #(.W(DATA_W)) u_logic (
        .kind  (ctrl.lk),
        .a     (rn),
        .b     (op2),
        .value (lg_val)
    );

    always_comb begin
        case (ctrl.cls)
            CLS_ARITH: value = ar_val;
            CLS_LOGIC: value = lg_val;
            default:   value = '0;
        endcase
        nxt.n = value[DATA_W-1];
        nxt.z = (value == '0);
        nxt.c = (ctrl.cls == CLS_ARITH) ? ar_c : sh_c;
        nxt.v = (ctrl.cls == CLS_ARITH) ? ar_v : cur.v;
        result    = value;
        write_en  = ctrl.writes;
        flags_out = (set_flags && ctrl.cls != CLS_NONE) ? nxt : cur;
    end

    always_comb begin
        if (is_compare(opcode)) begin
            assert_compare_no_write_R9: assert (!write_en)
                else $error("compare raised write enable");
        end
        if (!set_flags) begin
            assert_flags_hold_R11: assert (flags_out == flags_in)
                else $error("flags moved without set_flags");
        end
        if (set_flags && ctrl.cls == CLS_LOGIC) begin
            assert_logic_keeps_v_R8: assert (flags_out[0] == flags_in[0] && flags_out[1] == sh_c)
                else $error("logical op disturbed V or missed shifter carry");
        end
        if (opcode > 5'd16) begin
            assert_reserved_inert_R12: assert (!write_en && result == '0 && flags_out == flags_in)
                else $error("reserved opcode had an effect");
        end
    end

endmodule

// File: tb/shift_dp_alu_test.sv
module shift_dp_alu_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [4:0]  opcode = '0;
    logic [31:0] rn = '0;
    logic [31:0] rm = '0;
    logic [7:0]  imm8 = '0;
    logic [1:0]  op2_src = '0;
    logic [1:0]  shift_kind = '0;
    logic [4:0]  shift_amt = '0;
    logic        set_flags = 1'b0;
    logic [3:0]  flags_in = '0;
    logic [31:0] result;
    logic        write_en;
    logic [3:0]  flags_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_dp_alu uut (
        .opcode(opcode), .rn(rn), .rm(rm), .imm8(imm8), .op2_src(op2_src),
        .shift_kind(shift_kind), .shift_amt(shift_amt), .set_flags(set_flags),
        .flags_in(flags_in), .result(result), .write_en(write_en),
        .flags_out(flags_out)
    );

    function automatic void add_m(input logic [31:0] x, input logic [31:0] y, input int c,
                                  output logic [31:0] v, output logic co, output logic ov);
        longint s, sv;
        s  = longint'(x) + longint'(y) + longint'(c);
        sv = longint'($signed(x)) + longint'($signed(y)) + longint'(c);
        v  = s[31:0];
        co = s[32];
        ov = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
    endfunction

    function automatic void sub_m(input logic [31:0] x, input logic [31:0] y, input int c,
                                  output logic [31:0] v, output logic co, output logic ov);
        longint d, sv;
        d  = longint'(x) - longint'(y) - longint'(1 - c);
        sv = longint'($signed(x)) - longint'($signed(y)) - longint'(1 - c);
        v  = d[31:0];
        co = (d >= 0);
        ov = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
    endfunction

    // cls: 0 arithmetic, 1 logical, 2 compare, 3 reserved
    task automatic model(output logic [31:0] r, output logic w, output logic [3:0] fo,
                         output int cls);
        logic [31:0] op2, val;
        logic        sc, nc, nv;
        int          cin, o, a;
        cin = int'(flags_in[1]);
        o   = int'(opcode);
        a   = int'(shift_amt);
        op2 = rm;
        sc  = flags_in[1];
        if (op2_src == 2'd0) begin
            op2 = 32'(imm8);
        end else if (op2_src >= 2'd2) begin
            op2 = (rm >> 1) | (32'(cin) << 31);
            sc  = rm[0];
        end else if (a != 0) begin
            case (shift_kind)
                2'd0: begin longint t; t = longint'(rm) << a; op2 = t[31:0]; sc = t[32]; end
                2'd1: begin op2 = rm >> a; sc = 1'((rm >> (a - 1)) & 32'd1); end
                2'd2: begin op2 = 32'($signed(rm) >>> a); sc = 1'((rm >> (a - 1)) & 32'd1); end
                default: begin op2 = (rm >> a) | (rm << (32 - a)); sc = op2[31]; end
            endcase
        end
        nc = sc;
        nv = flags_in[0];
        val = 32'd0;
        if (o <= 6) cls = 1; else if (o <= 12) cls = 0; else if (o <= 16) cls = 2; else cls = 3;
        case (o)
            0: val = op2;
            1: val = ~op2;
            2, 15: val = rn & op2;
            3: val = rn | op2;
            4, 16: val = rn ^ op2;
            5: val = rn | ~op2;
            6: val = rn & ~op2;
            7, 14: add_m(rn, op2, 0, val, nc, nv);
            8: add_m(rn, op2, cin, val, nc, nv);
            9, 13: sub_m(rn, op2, 1, val, nc, nv);
            10: sub_m(rn, op2, cin, val, nc, nv);
            11: sub_m(op2, rn, 1, val, nc, nv);
            12: sub_m(op2, rn, cin, val, nc, nv);
            default: val = 32'd0;
        endcase
        r  = val;
        w  = (o <= 12);
        fo = (set_flags && cls != 3) ? {val[31], val == 32'd0, nc, nv} : flags_in;
    endtask

    task automatic check(input string tag, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic compare_all(input string focus);
        logic [31:0] r;
        logic        w;
        logic [3:0]  fo;
        int          cls;
        string       rt, wt, ft;
        model(r, w, fo, cls);
        case (cls)
            0: begin rt = "R5"; wt = "R13"; ft = "R6"; end
            1: begin rt = "R7"; wt = "R13"; ft = "R8"; end
            2: begin rt = "R9"; wt = "R9";  ft = "R9"; end
            default: begin rt = "R12"; wt = "R12"; ft = "R12"; end
        endcase
        if (!set_flags) ft = "R11";
        if (focus != "") rt = focus;
        check(rt, "result", result, r);
        check(wt, "write_en", 32'(write_en), 32'(w));
        check(ft, "flags C/V", 32'(flags_out[1:0]), 32'(fo[1:0]));
        if (set_flags && cls != 3)
            check("R10", "flags N/Z", 32'(flags_out[3:2]), 32'(fo[3:2]));
        else
            check(ft, "flags N/Z", 32'(flags_out[3:2]), 32'(fo[3:2]));
    endtask

    task automatic vec(input string focus, input int op, input logic [31:0] a,
                       input logic [31:0] b, input logic [7:0] im, input int src,
                       input int kind, input int amt, input bit sf, input logic [3:0] fl);
        @(posedge clk);
        #1;
        opcode = 5'(op); rn = a; rm = b; imm8 = im; op2_src = 2'(src);
        shift_kind = 2'(kind); shift_amt = 5'(amt); set_flags = sf; flags_in = fl;
        @(negedge clk);
        compare_all(focus);
    endtask

    initial begin
        // idle inputs: MOV of immediate 0, flags held
        @(negedge clk);
        check("R11", "idle result", result, 32'd0);
        check("R13", "idle write_en", 32'(write_en), 32'd1);
        check("R11", "idle flags", 32'(flags_out), 32'd0);

        // R1 immediate, carry passes
        vec("R1", 0, 0, 32'hFFFFFFFF, 8'hA5, 0, 0, 0, 1, 4'b0010);
        vec("R1", 0, 0, 0, 8'hFF, 0, 3, 7, 1, 4'b0000);
        // R2 each shift type at amounts 1 and 31
        vec("R2", 0, 0, 32'h80000001, 0, 1, 0, 1, 1, 4'b0000);
        vec("R2", 0, 0, 32'h00000001, 0, 1, 0, 31, 1, 4'b0000);
        vec("R2", 0, 0, 32'h80000001, 0, 1, 1, 1, 1, 4'b0000);
        vec("R2", 0, 0, 32'h80000000, 0, 1, 1, 31, 1, 4'b0010);
        vec("R2", 0, 0, 32'h80000000, 0, 1, 2, 31, 1, 4'b0000);
        vec("R2", 0, 0, 32'hF0000008, 0, 1, 2, 4, 1, 4'b0000);
        vec("R2", 0, 0, 32'h00000003, 0, 1, 3, 1, 1, 4'b0000);
        vec("R2", 0, 0, 32'h12345678, 0, 1, 3, 31, 1, 4'b0000);
        // R3 zero amount for every kind, both carry values
        for (int k = 0; k < 4; k++) begin
            vec("R3", 0, 0, 32'hC0FFEE01, 0, 1, k, 0, 1, 4'b0010);
            vec("R3", 0, 0, 32'h80000000, 0, 1, k, 0, 1, 4'b0000);
        end
        // R4 rotate through carry
        vec("R4", 0, 0, 32'h00000001, 0, 2, 0, 0, 1, 4'b0000);
        vec("R4", 0, 0, 32'h00000002, 0, 3, 0, 0, 1, 4'b0010);
        // R5/R6 arithmetic edges
        vec("", 7, 32'h7FFFFFFF, 0, 8'h01, 0, 0, 0, 1, 4'b0000);
        vec("", 7, 32'hFFFFFFFF, 0, 8'h01, 0, 0, 0, 1, 4'b0000);
        vec("", 8, 32'hFFFFFFFE, 0, 8'h01, 0, 0, 0, 1, 4'b0010);
        vec("", 9, 32'h80000000, 0, 8'h01, 0, 0, 0, 1, 4'b0000);
        vec("", 10, 32'h00000005, 0, 8'h05, 0, 0, 0, 1, 4'b0000);
        vec("", 10, 32'h00000005, 0, 8'h05, 0, 0, 0, 1, 4'b0010);
        vec("", 11, 32'h00000010, 0, 8'h03, 0, 0, 0, 1, 4'b0000);
        vec("", 12, 32'h00000003, 0, 8'h03, 0, 0, 0, 1, 4'b0000);
        vec("", 12, 32'h80000000, 0, 8'h00, 0, 0, 0, 1, 4'b0010);
        // R7/R8 logic with V set, shifter carry set
        for (int o = 0; o <= 6; o++)
            vec("", o, 32'h0F0F00FF, 32'hFF00F0F1, 0, 1, 1, 1, 1, 4'b0001);
        // R9 compares, including equal operands (Z)
        vec("", 13, 32'h00000042, 0, 8'h42, 0, 0, 0, 1, 4'b0000);
        vec("", 14, 32'hFFFFFFFF, 0, 8'h01, 0, 0, 0, 1, 4'b0000);
        vec("", 15, 32'h000000F0, 0, 8'h0F, 0, 0, 0, 1, 4'b0011);
        vec("", 16, 32'h000000AA, 0, 8'hAA, 0, 0, 0, 1, 4'b1001);
        // R11 flags hold; R12 reserved codes
        vec("", 9, 32'd1, 0, 8'd1, 0, 0, 0, 0, 4'b1010);
        vec("", 17, 32'd5, 32'd9, 8'd3, 1, 0, 2, 1, 4'b0101);
        vec("", 31, 32'hFFFFFFFF, 32'd1, 8'd3, 2, 0, 0, 1, 4'b1010);

        // pseudo-random sweep with biased shift amounts
        for (int i = 0; i < 4000; i++) begin
            int amt;
            int pick;
            pick = int'($urandom_range(0, 3));
            amt  = (pick == 0) ? 0 : (pick == 1) ? 1 : (pick == 2) ? 31 : int'($urandom_range(0, 31));
            vec("", int'($urandom_range(0, 20)), $urandom(), $urandom(), 8'($urandom()),
                int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), amt,
                1'($urandom_range(0, 3) != 0), 4'($urandom()));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule